// File: doc/BRIEF.md
# Consumer Audio Biphase Transmitter

This block turns a stereo stream of 24-bit two's-complement samples into one biphase-mark-coded serial line for consumer digital audio. It runs from a system clock at 256 times the sample rate. Each frame lasts 256 clocks and holds a left sub-frame followed by a right sub-frame. Each sub-frame is 32 slots long. Every slot is split into two half-bit line states, and each state lasts two clocks.

A sample strobe captures the left and right words and their unreliable flags into a holding stage at any point in a frame. The frame timer copies the most recent capture into the outgoing frame at each frame start. Each sub-frame carries a synchronising preamble, the sample, a validity bit, a zero user bit, one channel status bit and an even-parity bit. The channel status word is 192 bits long and is produced inside the block. Its content is fixed except for the de-emphasis field, which follows a control input sampled at every frame start.

Top module: `iec_tx`

## Requirements
- R1: While rst_ni is low, line_o is 0. The first frame after reset release is frame 0 of a block, so its left sub-frame opens with the B preamble, starting from a previous line level of 0.
- R2: One line state lasts 2 clocks. Each sub-frame holds 64 states, the left sub-frame comes first, and a frame is 256 clocks. The block index advances only at frame boundaries and wraps after 192 frames.
- R3: The 8 preamble states are, for a previous level of 0: B = 11101000, M = 11100010, W = 11100100, with the first state sent first. Each pattern is inverted when the previous level is 1. The left sub-frame uses B in block frame 0 and M in every other frame. The right sub-frame always uses W.
- R4: Slots 4 to 27 carry the sample, LSB in slot 4 and MSB in slot 27. Each frame sends the last words captured on strobe_i before its start. A strobe in the frame-start cycle itself supplies that same frame.
- R5: Each data slot is sent as two states. The first state is the inverse of the previous state. The second state inverts again for a 1 and repeats the first state for a 0.
- R6: Slot 28 carries the channel's unreliable flag (1 = unreliable, 0 = reliable). Slot 29 is always 0.
- R7: Slot 30 of frame n in the block carries channel status bit n. Bits 0 and 1 are 0 and bit 2 is 1. Bits 8 to 15 are 0,0,1,1,0,0,0,1 in that order. Bits 24 and 25 are 1. All other bits except 3 and 4 are 0.
- R8: Channel status bits 3 and 4 are both 0 when deemph_on_i is 1 and both 1 when it is 0. The input is sampled only in the frame-start cycle.
- R9: Slot 31 makes the number of ones in slots 4 to 31 of each sub-frame even.
- R10: Both sub-frames of a frame carry the same channel status bit.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | System clock, 256 times the sample rate |
| rst_ni | input | 1 | Asynchronous reset, active low |
| strobe_i | input | 1 | Sample capture strobe |
| left_i | input | 24 | Left sample, two's complement |
| right_i | input | 24 | Right sample, two's complement |
| left_bad_i | input | 1 | Left sample unreliable |
| right_bad_i | input | 1 | Right sample unreliable |
| deemph_on_i | input | 1 | De-emphasis in use; drives channel status bits 3 and 4 |
| line_o | output | 1 | Biphase-mark line state |

## Verification
Two events can fall in the same cycle: the frame-start load and a sample capture. In one frame out of every four, the bench raises strobe_i exactly in the frame-start cycle and expects the new words to appear in that frame rather than the old holding contents. The other frames use strobes placed mid-frame, double strobes and no strobe at all. The de-emphasis input is changed both at a frame start and halfway through a frame, where it must have no effect until the next frame. A behavioural model builds every frame's 128 line states from the requirements and compares them against line_o on every clock across a block wrap.

// File: rtl/iec_tx_pkg.sv
package iec_tx_pkg;
  typedef enum logic [1:0] {PRE_B = 2'd0, PRE_M = 2'd1, PRE_W = 2'd2} pre_e;

  // preamble states, first state in bit 7, for a previous level of 0
  function automatic logic [7:0] pre_pat(pre_e p);
    case (p)
      PRE_B:   return 8'b1110_1000;
      PRE_M:   return 8'b1110_0010;
      default: return 8'b1110_0100;
    endcase
  endfunction
endpackage

// File: rtl/iec_frame_timer.sv
module iec_frame_timer #(
  parameter int CNT_W      = 8,
  parameter int BLK_FRAMES = 192,
  parameter int BLK_W      = 8
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  output logic [CNT_W-1:0] cnt_o,
  output logic [BLK_W-1:0] blk_o
);
  localparam logic [BLK_W-1:0] BLK_LAST = BLK_W'(BLK_FRAMES - 1);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      cnt_o <= '0;
      blk_o <= '0;
    end else begin
      cnt_o <= cnt_o + 1'b1;
      if (&cnt_o) blk_o <= (blk_o == BLK_LAST) ? '0 : blk_o + 1'b1;
    end
  end
endmodule

// File: rtl/iec_cs_gen.sv
module iec_cs_gen #(
  parameter int BLK_W = 8
) (
  input  logic [BLK_W-1:0] idx_i,
  input  logic             deemph_on_i,
  output logic             cs_o
);
  localparam logic [7:0] CATEGORY = 8'b0011_0001; // bit 8 in CATEGORY[7]

  int i;
  always_comb begin
    i    = int'(idx_i);
    cs_o = 1'b0;
    if (i == 2)                   cs_o = 1'b1;
    else if (i == 3 || i == 4)    cs_o = !deemph_on_i;
    else if (i >= 8 && i <= 15)   cs_o = CATEGORY[3'(15 - i)];
    else if (i == 24 || i == 25)  cs_o = 1'b1;
  end
endmodule

// File: rtl/iec_bmc_line.sv
module iec_bmc_line
  import iec_tx_pkg::*;
#(
  parameter int CNT_W = 8
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic [CNT_W-1:0] cnt_i,
  input  pre_e             pre_i,
  input  logic             data_i,
  output logic             line_o
);
  localparam int SLOT_W = CNT_W - 3;

  logic              half, is_pre, pol, nxt;
  logic [SLOT_W-1:0] slot;
  logic [2:0]        k;
  logic [7:0]        pat;
  logic              line_q, pol_q;

  assign half   = cnt_i[1];
  assign slot   = cnt_i[CNT_W-2:2];
  assign is_pre = (slot[SLOT_W-1:2] == '0);
  assign k      = {slot[1:0], half};
  assign pat    = pre_pat(pre_i);
  assign pol    = (k == 3'd0) ? line_q : pol_q;

  always_comb begin
    if (is_pre)    nxt = pat[~k] ^ pol;
    else if (half) nxt = line_q ^ data_i;
    else           nxt = ~line_q;
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      line_q <= 1'b0;
      pol_q  <= 1'b0;
    end else if (!cnt_i[0]) begin
      line_q <= nxt;
      if (is_pre && k == 3'd0) pol_q <= line_q;
    end
  end

  assign line_o = line_q;
endmodule

// File: rtl/iec_tx.sv
module iec_tx
  import iec_tx_pkg::*;
#(
  parameter int SAMPLE_W   = 24,
  parameter int BLK_FRAMES = 192
) (
  input  logic                clk_i,
  input  logic                rst_ni,
  input  logic                strobe_i,
  input  logic [SAMPLE_W-1:0] left_i,
  input  logic [SAMPLE_W-1:0] right_i,
  input  logic                left_bad_i,
  input  logic                right_bad_i,
  input  logic                deemph_on_i,
  output logic                line_o
);
  localparam int SLOTS  = SAMPLE_W + 8;
  localparam int CNT_W  = $clog2(8 * SLOTS);
  localparam int SLOT_W = $clog2(SLOTS);
  localparam int BLK_W  = $clog2(BLK_FRAMES);

  logic [CNT_W-1:0]               cnt;
  logic [BLK_W-1:0]               blk;
  logic                           cs_bit, cs_q, sub, data_bit;
  logic [SLOT_W-1:0]              slot;
  logic [1:0][SAMPLE_W-1:0]       smp_in, hold_q, samp_q;
  logic [1:0]                     bad_in, hold_bad_q, bad_q;
  logic [1:0][SLOTS-1:0]          pay;
  pre_e                           pre;

  iec_frame_timer #(.CNT_W(CNT_W), .BLK_FRAMES(BLK_FRAMES), .BLK_W(BLK_W)) u_timer (
    .clk_i, .rst_ni, .cnt_o(cnt), .blk_o(blk)
  );

  iec_cs_gen #(.BLK_W(BLK_W)) u_cs (
    .idx_i(blk), .deemph_on_i, .cs_o(cs_bit)
  );

  assign smp_in = {right_i, left_i};
  assign bad_in = {right_bad_i, left_bad_i};

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      hold_q     <= '0;
      hold_bad_q <= '0;
      samp_q     <= '0;
      bad_q      <= '0;
      cs_q       <= 1'b0;
    end else begin
      if (strobe_i) begin
        hold_q     <= smp_in;
        hold_bad_q <= bad_in;
      end
      if (cnt == '0) begin
        samp_q <= strobe_i ? smp_in : hold_q;   // fresh strobe wins at frame start
        bad_q  <= strobe_i ? bad_in : hold_bad_q;
        cs_q   <= cs_bit;
      end
    end
  end

  for (genvar ch = 0; ch < 2; ch++) begin : g_ch
    logic par;
    assign par     = ^{cs_q, bad_q[ch], samp_q[ch]};
    assign pay[ch] = {par, cs_q, 1'b0, bad_q[ch], samp_q[ch], 4'b0000};
  end

  assign sub      = cnt[CNT_W-1];
  assign slot     = cnt[CNT_W-2:2];
  assign data_bit = pay[sub][slot];
  assign pre      = sub ? PRE_W : ((blk == '0) ? PRE_B : PRE_M);

  iec_bmc_line #(.CNT_W(CNT_W)) u_line (
    .clk_i, .rst_ni, .cnt_i(cnt), .pre_i(pre), .data_i(data_bit), .line_o
  );
endmodule

// File: rtl/iec_tx_chk.sv
module iec_tx_chk #(
  parameter int CNT_W = 8,
  parameter int BLK_W = 8
) (
  input logic             clk_i,
  input logic             rst_ni,
  input logic             line_o,
  input logic [CNT_W-1:0] cnt,
  input logic [BLK_W-1:0] blk,
  input logic             cs_q
);
  always @(negedge clk_i)
    if (!rst_ni) AST_RESET_IDLE: assert (line_o == 1'b0); // R1

  AST_STATE_TWO_CLK: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !$stable(line_o) |-> cnt[0]); // R2

  AST_BLK_AT_BOUNDARY: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (cnt != '0) |-> $stable(blk)); // R2

  AST_BLK_RANGE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    blk < BLK_W'(192)); // R3

  AST_DATA_EDGE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (cnt[1:0] == 2'b00 && cnt[CNT_W-2:2] >= 4) |=> !$stable(line_o)); // R5

  AST_CS_TAIL_ZERO: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (cnt == CNT_W'(1) && blk >= BLK_W'(30)) |-> !cs_q); // R7
endmodule

bind iec_tx iec_tx_chk u_chk (
  .clk_i(clk_i), .rst_ni(rst_ni), .line_o(line_o), .cnt(cnt), .blk(blk), .cs_q(cs_q)
);

// File: tb/sim_iec_tx.sv
module sim_iec_tx;
  localparam int FRAMES   = 196;
  localparam int WATCHDOG = 150000;

  logic        clk_i = 1'b0, rst_ni = 1'b0, strobe_i = 1'b0;
  logic [23:0] left_i = '0, right_i = '0;
  logic        left_bad_i = 1'b0, right_bad_i = 1'b0, deemph_on_i = 1'b0;
  logic        line_o;

  int n_tests = 0, n_fail = 0;
  bit done = 0;

  iec_tx u0 (.*);

  always #4 clk_i = ~clk_i;

  // ---------------- reference model ----------------
  int   n;
  bit   lvl, exp_line;
  bit   q[$];
  bit [23:0] h_s [2];
  bit        h_b [2];

  function automatic bit cs_ref(int i, bit de);
    bit [7:0] cat = 8'b0011_0001;
    if (i == 2) return 1;
    if (i == 3 || i == 4) return !de;
    if (i >= 8 && i <= 15) return cat[15 - i];
    if (i == 24 || i == 25) return 1;
    return 0;
  endfunction

  task automatic build(int f, bit [23:0] s0, bit [23:0] s1, bit b0, bit b1, bit cs);
    bit [7:0] pat;
    bit [27:0] bits;
    bit p;
    q.delete();
    for (int ch = 0; ch < 2; ch++) begin
      if (ch == 1) pat = 8'b11100100;
      else if (f == 0) pat = 8'b11101000;
      else pat = 8'b11100010;
      p = lvl;
      for (int i = 0; i < 8; i++) begin
        lvl = pat[7 - i] ^ p;
        q.push_back(lvl);
      end
      bits[23:0] = (ch == 0) ? s0 : s1;
      bits[24]   = (ch == 0) ? b0 : b1;
      bits[25]   = 1'b0;
      bits[26]   = cs;
      bits[27]   = ^bits[26:0];
      for (int b = 0; b < 28; b++) begin
        lvl = !lvl;
        q.push_back(lvl);
        if (bits[b]) lvl = !lvl;
        q.push_back(lvl);
      end
    end
  endtask

  always @(posedge clk_i) begin
    if (!rst_ni) begin
      n = 0; lvl = 0; exp_line = 0;
      h_s[0] = '0; h_s[1] = '0; h_b[0] = 0; h_b[1] = 0;
    end else begin
      if (n % 256 == 0)
        build((n / 256) % 192,
              strobe_i ? left_i  : h_s[0], strobe_i ? right_i : h_s[1],
              strobe_i ? left_bad_i : h_b[0], strobe_i ? right_bad_i : h_b[1],
              cs_ref((n / 256) % 192, deemph_on_i));
      if (strobe_i) begin
        h_s[0] = left_i; h_s[1] = right_i; h_b[0] = left_bad_i; h_b[1] = right_bad_i;
      end
      exp_line = q[(n % 256) / 2];
      n++;
    end
  end

  // ---------------- comparison ----------------
  task automatic check(bit ok, string tag, bit act, bit exp);
    n_tests++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s: line_o=%0b expected %0b (cycle %0d)", tag, act, exp, n);
    end
  endtask

  function automatic string tag_of(int c);
    int slot = ((c % 256) / 4) % 32;
    if (slot < 4)   return (c < 256) ? "R1 R2 R3" : "R2 R3";
    if (slot < 28)  return "R4 R5";
    if (slot < 30)  return "R6 R5";
    if (slot == 30) return "R7 R8 R10";
    return "R9";
  endfunction

  always @(negedge clk_i) begin
    if (!done) begin
      if (!rst_ni) check(line_o === 1'b0, "R1", line_o, 1'b0);
      else if (n > 0) check(line_o === exp_line, tag_of(n - 1), line_o, exp_line);
    end
  end

  // ---------------- stimulus ----------------
  initial begin
    repeat (4) @(negedge clk_i);
    rst_ni = 1'b1;
    for (int c = 0; c < FRAMES * 256; c++) begin
      int pos = c % 256;
      int f   = c / 256;
      int mode = f % 4;
      bit stb;
      stb = (mode == 0 && pos == 0) || (mode == 1 && pos == 37) ||
            (mode == 3 && (pos == 10 || pos == 200));
      strobe_i = stb;
      if (stb) begin
        case (f)
          0: begin left_i = 24'h800000; right_i = 24'h7FFFFF; end
          1: begin left_i = 24'hFFFFFF; right_i = 24'h000001; end
          default: begin left_i = 24'($urandom); right_i = 24'($urandom); end
        endcase
        left_bad_i  = ($urandom % 5) == 0;
        right_bad_i = ($urandom % 3) == 0;
      end
      if (pos == 0 && f % 7 == 3) deemph_on_i = ~deemph_on_i;
      if (pos == 128 && f % 5 == 1) deemph_on_i = ~deemph_on_i;
      @(negedge clk_i);
    end
    done = 1;
    $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end

  initial begin
    repeat (WATCHDOG) @(posedge clk_i);
    if (!done) begin
      done = 1;
      n_tests++; n_fail++;
      $display("FAIL watchdog: run did not complete");
      $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
      $finish;
    end
  end
endmodule